// File: doc/BRIEF.md
# Shared-Adder Signed ALU

This block is a combinational arithmetic unit for signed two's-complement words. It contains one adder. Three multiplexers, steered by small control decoders, let that adder perform eight functions. An inversion mux on operand A and a carry-in select turn the adder into a subtractor, an absolute-value unit or a comparator. A result-select mux then picks operand A or operand B to produce a signed maximum or minimum.

The caller supplies:
- the two operands;
- a 3-bit function code;
- the stored carry flag, which comes from flag state held outside the block.

The block returns:
- the result word;
- the adder carry out;
- the three mux control values, so that surrounding logic can observe them.

There are no registers. Flag storage lies outside the block, and so does saturation of the absolute value.

Top module: `shared_adder_alu`

## Requirements
- R1: Function 000 gives result b+a. Function 001 gives b+a+C, where C is `carry_i`. For both, `carry_o` is bit WIDTH of the unsigned sum.
- R2: Function 010 gives b−a with `carry_o` equal to the carry out of b+~a+1. Function 011 gives b−a−1+C with `carry_o` equal to the carry out of b+~a+C.
- R3: Function 100 gives |a| with no saturation, so the most negative word returns unchanged. `carry_o` is 0 for this function.
- R4: Function 101 gives b−a on `result_o` and the same `carry_o` as function 010.
- R5: Function 110 gives the signed maximum of a and b. This holds even when b−a overflows.
- R6: Function 111 gives the signed minimum of a and b. This holds even when b−a overflows.
- R7: `ci_sel_o` encodes 00 = constant 0, 01 = constant 1 and 10 = carry flag. The value per function is:
  - 000 uses 00.
  - 001 and 011 use 10.
  - 010, 101, 110 and 111 use 01.
  - 100 uses 01 when a is negative and 00 otherwise.
- R8: `opa_inv_o` is 1 for functions 010, 011, 101, 110 and 111, and 0 for 000 and 001. For 100 it equals the sign bit of a.
- R9: For functions 110 and 111 with a ≠ b, `minmax_sel_o` is 1 when the result is operand A and 0 when it is operand B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opa_i | input | WIDTH | Operand A, signed |
| opb_i | input | WIDTH | Operand B, signed |
| func_i | input | 3 | Function code |
| carry_i | input | 1 | Stored carry flag |
| result_o | output | WIDTH | Function result |
| carry_o | output | 1 | Adder carry out |
| opa_inv_o | output | 1 | Operand-A inversion control |
| ci_sel_o | output | 2 | Carry-in select control |
| minmax_sel_o | output | 1 | Max/min result select, 1 = operand A |

## Verification
The bench builds the block with the default WIDTH of 16. At that width the word limits can be written out directly: 0x7FFF, 0x8000, 0x8001, zero and ±1. Every pairing of these with every function code is applied. This covers the overflowing b−a cases that min and max must survive, and the unsaturated absolute value of 0x8000. A long run of random operand and carry values then exercises the ordinary cases of all eight functions.

// File: rtl/alu_pkg.sv
package alu_pkg;
  typedef enum logic [2:0] {
    FN_ADD  = 3'b000,
    FN_ADDC = 3'b001,
    FN_SUB  = 3'b010,
    FN_SUBC = 3'b011,
    FN_ABS  = 3'b100,
    FN_CMP  = 3'b101,
    FN_MAX  = 3'b110,
    FN_MIN  = 3'b111
  } alu_fn_e;

  typedef enum logic [1:0] {
    CI_ZERO = 2'b00,
    CI_ONE  = 2'b01,
    CI_FLAG = 2'b10
  } ci_sel_e;
endpackage

// File: rtl/alu_opa_ctrl.sv
module alu_opa_ctrl
  import alu_pkg::*;
(
  input  logic [2:0] func_i,
  input  logic       opa_sign_i,
  output logic       opa_inv_o,
  output logic [1:0] ci_sel_o
);
  alu_fn_e fn;
  assign fn = alu_fn_e'(func_i);

  always_comb begin
    opa_inv_o = 1'b1;
    ci_sel_o  = CI_ONE;
    unique case (fn)
      FN_ADD:  begin opa_inv_o = 1'b0; ci_sel_o = CI_ZERO; end
      FN_ADDC: begin opa_inv_o = 1'b0; ci_sel_o = CI_FLAG; end
      FN_SUBC: begin opa_inv_o = 1'b1; ci_sel_o = CI_FLAG; end
      // negate only when A is negative
      FN_ABS:  begin
        opa_inv_o = opa_sign_i;
        ci_sel_o  = opa_sign_i ? CI_ONE : CI_ZERO;
      end
      default: begin opa_inv_o = 1'b1; ci_sel_o = CI_ONE; end
    endcase
  end
endmodule

// File: rtl/alu_minmax_ctrl.sv
module alu_minmax_ctrl
  import alu_pkg::*;
(
  input  logic [2:0] func_i,
  input  logic       opa_sign_i,
  input  logic       opb_sign_i,
  input  logic       carry_i,
  output logic       sel_a_o
);
  alu_fn_e fn;
  logic    signs_differ;
  assign fn           = alu_fn_e'(func_i);
  assign signs_differ = opa_sign_i ^ opb_sign_i;

  // carry of b+~a+1 set means b >= a; valid only when signs agree
  always_comb begin
    sel_a_o = 1'b0;
    if (fn == FN_MAX)
      sel_a_o = signs_differ ? opb_sign_i : ~carry_i;
    else if (fn == FN_MIN)
      sel_a_o = signs_differ ? opa_sign_i : carry_i;
  end
endmodule

// File: rtl/alu_adder_dp.sv
module alu_adder_dp
  import alu_pkg::*;
#(
  parameter int unsigned WIDTH = 16
) (
  input  logic [WIDTH-1:0] opa_i,
  input  logic [WIDTH-1:0] opb_i,
  input  logic             zero_b_i,
  input  logic             opa_inv_i,
  input  logic [1:0]       ci_sel_i,
  input  logic             carry_flag_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             carry_o
);
  logic [WIDTH-1:0] a_eff, b_eff;
  logic             ci;
  logic [WIDTH:0]   full;

  assign a_eff = opa_inv_i ? ~opa_i : opa_i;
  assign b_eff = zero_b_i ? '0 : opb_i;

  always_comb begin
    unique case (ci_sel_e'(ci_sel_i))
      CI_ONE:  ci = 1'b1;
      CI_FLAG: ci = carry_flag_i;
      default: ci = 1'b0;
    endcase
  end

  assign full    = {1'b0, b_eff} + {1'b0, a_eff} + {{WIDTH{1'b0}}, ci};
  assign sum_o   = full[WIDTH-1:0];
  assign carry_o = full[WIDTH];
endmodule

// File: rtl/shared_adder_alu.sv
module shared_adder_alu
  import alu_pkg::*;
#(
  parameter int unsigned WIDTH = 16
) (
  input  logic [WIDTH-1:0] opa_i,
  input  logic [WIDTH-1:0] opb_i,
  input  logic [2:0]       func_i,
  input  logic             carry_i,
  output logic [WIDTH-1:0] result_o,
  output logic             carry_o,
  output logic             opa_inv_o,
  output logic [1:0]       ci_sel_o,
  output logic             minmax_sel_o
);
  localparam int unsigned MSB = WIDTH - 1;
  localparam logic [WIDTH-1:0] MOST_NEG = {1'b1, {(WIDTH-1){1'b0}}};

  alu_fn_e          fn;
  logic [WIDTH-1:0] sum;
  logic             add_carry;
  logic             is_minmax;

  assign fn        = alu_fn_e'(func_i);
  assign is_minmax = (fn == FN_MAX) || (fn == FN_MIN);

  alu_opa_ctrl u_opa_ctrl (
    .func_i     (func_i),
    .opa_sign_i (opa_i[MSB]),
    .opa_inv_o  (opa_inv_o),
    .ci_sel_o   (ci_sel_o)
  );

  alu_adder_dp #(.WIDTH(WIDTH)) u_adder_dp (
    .opa_i        (opa_i),
    .opb_i        (opb_i),
    .zero_b_i     (fn == FN_ABS),
    .opa_inv_i    (opa_inv_o),
    .ci_sel_i     (ci_sel_o),
    .carry_flag_i (carry_i),
    .sum_o        (sum),
    .carry_o      (add_carry)
  );

  alu_minmax_ctrl u_minmax_ctrl (
    .func_i     (func_i),
    .opa_sign_i (opa_i[MSB]),
    .opb_sign_i (opb_i[MSB]),
    .carry_i    (add_carry),
    .sel_a_o    (minmax_sel_o)
  );

  assign result_o = is_minmax ? (minmax_sel_o ? opa_i : opb_i) : sum;
  assign carry_o  = add_carry;

  always_comb begin
    if (!$isunknown({opa_i, opb_i, func_i, carry_i})) begin
      if (fn == FN_ABS && opa_i != MOST_NEG)
        AST_ABS_NONNEG: assert (!result_o[MSB]) else $error("abs negative"); // R3
      if (fn == FN_ABS)
        AST_ABS_NO_CARRY: assert (!carry_o) else $error("abs carry"); // R3
      if (fn == FN_MAX)
        AST_MAX_UPPER: assert ($signed(result_o) >= $signed(opa_i) &&
                               $signed(result_o) >= $signed(opb_i)) else $error("max low"); // R5
      if (fn == FN_MIN)
        AST_MIN_LOWER: assert ($signed(result_o) <= $signed(opa_i) &&
                               $signed(result_o) <= $signed(opb_i)) else $error("min high"); // R6
    end
  end
endmodule

// File: tb/shared_adder_alu_tb.sv
module shared_adder_alu_tb;
  localparam int W = 16;
  localparam int MASK = (1 << W) - 1;

  logic         clk = 1'b0;
  logic [W-1:0] opa, opb, res;
  logic [2:0]   fn;
  logic         cf, co, inv, msel;
  logic [1:0]   cis;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  shared_adder_alu #(.WIDTH(W)) u_dut (
    .opa_i(opa), .opb_i(opb), .func_i(fn), .carry_i(cf),
    .result_o(res), .carry_o(co), .opa_inv_o(inv),
    .ci_sel_o(cis), .minmax_sel_o(msel)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s fn=%0d a=%h b=%h c=%0d actual=%h expected=%h",
               tag, fn, opa, opb, cf, act, exp);
    end
  endtask

  function automatic int sx(input int v);
    return (v & (1 << (W-1))) ? v - (1 << W) : v;
  endfunction

  task automatic apply(input int f, input int a, input int b, input int c);
    int s, er, ec, ea, eb, ci_exp;
    @(posedge clk);
    #1;
    fn = f[2:0]; opa = a[W-1:0]; opb = b[W-1:0]; cf = c[0];
    @(negedge clk);
    ea = a & MASK; eb = b & MASK;
    case (f)
      0: begin s = eb + ea;                  er = s & MASK; ec = (s >> W) & 1;
           chk("R1 add", res, er); chk("R1 add carry", co, ec);
           chk("R8 inv", inv, 0);  chk("R7 cisel", cis, 0); end
      1: begin s = eb + ea + c;              er = s & MASK; ec = (s >> W) & 1;
           chk("R1 addc", res, er); chk("R1 addc carry", co, ec);
           chk("R8 inv", inv, 0);   chk("R7 cisel", cis, 2); end
      2, 5: begin s = eb + ((~ea) & MASK) + 1; er = (eb - ea) & MASK; ec = (s >> W) & 1;
           chk(f == 2 ? "R2 sub" : "R4 cmp", res, er);
           chk(f == 2 ? "R2 sub carry" : "R4 cmp carry", co, ec);
           chk("R8 inv", inv, 1); chk("R7 cisel", cis, 1); end
      3: begin s = eb + ((~ea) & MASK) + c;  er = (eb - ea - 1 + c) & MASK; ec = (s >> W) & 1;
           chk("R2 subc", res, er); chk("R2 subc carry", co, ec);
           chk("R8 inv", inv, 1);   chk("R7 cisel", cis, 2); end
      4: begin
           er = (sx(ea) < 0) ? ((-sx(ea)) & MASK) : ea;
           ci_exp = (sx(ea) < 0) ? 1 : 0;
           chk("R3 abs", res, er); chk("R3 abs carry", co, 0);
           chk("R8 inv", inv, ci_exp); chk("R7 cisel", cis, ci_exp); end
      6: begin
           er = (sx(ea) > sx(eb)) ? ea : eb;
           chk("R5 max", res, er); chk("R8 inv", inv, 1); chk("R7 cisel", cis, 1);
           if (ea != eb) chk("R9 sel", msel, (sx(ea) > sx(eb)) ? 1 : 0); end
      default: begin
           er = (sx(ea) < sx(eb)) ? ea : eb;
           chk("R6 min", res, er); chk("R8 inv", inv, 1); chk("R7 cisel", cis, 1);
           if (ea != eb) chk("R9 sel", msel, (sx(ea) < sx(eb)) ? 1 : 0); end
    endcase
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected<150000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int corners[8];
    corners = '{0, 1, 'hFFFF, 'h7FFF, 'h8000, 'h8001, 123, 'hFF85};
    fn = 3'd0; opa = '0; opb = '0; cf = 1'b0;
    // R3: unsaturated abs of most negative word
    apply(4, 'h8000, 0, 0);
    // R5 R6: overflowing b-a pairs
    apply(6, 'h8000, 'h7FFF, 0);
    apply(7, 'h8000, 'h7FFF, 0);
    apply(6, 'h7FFF, 'h8000, 1);
    apply(7, 'h7FFF, 'h8000, 1);
    for (int f = 0; f < 8; f++)
      for (int i = 0; i < 8; i++)
        for (int j = 0; j < 8; j++)
          for (int c = 0; c < 2; c++)
            apply(f, corners[i], corners[j], c);
    for (int n = 0; n < 3000; n++)
      apply(n % 8, int'($urandom) & MASK, int'($urandom) & MASK, int'($urandom) & 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule